// File: doc/BRIEF.md
# Pseudo-Random Re-Authentication Timer

This block sits beside the key-checking state machine of a logic-locked circuit. It decides when an unlocked circuit is forced back into its locked mode, and which locked state the circuit lands in. A free-running linear feedback shift register supplies the randomness. An up-counter measures the unlocked window. A two-state controller ties the register and the counter together.

When the key checker raises its authenticated flag, the controller takes the current shift-register value as the length of the next unlocked window. When that window has elapsed, the controller takes a second sample of the shift register. A fixed slice of that sample becomes the index of the locked state to return to. The controller then emits a one-cycle back-jump request and waits for the next authentication. The mean window is therefore about half the shift register's value range. This makes a wider register a direct trade between security and the time spent re-authenticating.

Top module: `reauth_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `jump_o` is 0 and `jump_idx_o` is 0. The shift register restarts from the seed (0xCE with the default 8-bit width).
- R2: The shift register is a Fibonacci register that shifts towards the MSB. The new LSB is the XOR of the tap bits (width 8: taps 8,6,5,4, i.e. bits 7,5,4,3). It steps on every clock after reset, whether the controller is idle or running, and it never holds zero.
- R3: While idle and not authenticated, the block raises no back-jump request, however long it waits.
- R4: A rising edge that finds the controller idle and `auth_i` high latches the current shift-register value as the period P, clears the counter and starts the window. A value of zero would be taken as 1.
- R5: The request `jump_o` is high in exactly one cycle: the cycle that follows the (P+1)-th rising edge after the accepting edge. It is low in every cycle of the window.
- R6: `jump_idx_o` takes the low IDX_W bits of the shift-register value present at the expiring edge. These are bits [2:0] at the default setting.
- R7: `jump_o` is a one-cycle pulse. `jump_idx_o` holds its value through the pulse and afterwards, and changes only at the next expiry.
- R8: Any activity on `auth_i` while a window is running is ignored. It neither restarts nor stretches the window.
- R9: After expiry the controller is idle in the pulse cycle. If `auth_i` is high in that cycle, the edge that ends the pulse starts a new window. Its period is the shift-register value of the pulse cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auth_i | input | 1 | Authenticated status from the key checker |
| jump_o | output | 1 | One-cycle back-jump request |
| jump_idx_o | output | IDX_W | Index of the locked state to land in |

## Verification
Two events can share a cycle: the back-jump request of one window, and the acceptance of the authentication that opens the next. The bench provokes this by holding `auth_i` high across the pulse cycle. The shared cycle is judged correct when two things hold. First, the following pulse must arrive exactly P+2 cycles later, where P is the bench's own shift-register value from the pulse cycle. Second, the index of the first pulse must remain intact. A second overlap, authentication arriving in the expiry cycle itself, is exercised by toggling `auth_i` throughout a window. It must have no effect on the window's timing.

// File: rtl/reauth_pkg.sv
package reauth_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrl_state_e;

  // Tap mask (bit t-1 set for tap t) of a maximal-length Fibonacci register.
  function automatic logic [15:0] fib_taps(input int unsigned width);
    logic [15:0] m;
    case (width)
      5:       m = 16'h0014; // 5,3
      6:       m = 16'h0030; // 6,5
      7:       m = 16'h0060; // 7,6
      8:       m = 16'h00B8; // 8,6,5,4
      9:       m = 16'h0110; // 9,5
      10:      m = 16'h0240; // 10,7
      11:      m = 16'h0500; // 11,9
      12:      m = 16'h0829; // 12,6,4,1
      13:      m = 16'h100D; // 13,4,3,1
      14:      m = 16'h2015; // 14,5,3,1
      default: m = 16'h6000; // 15,14
    endcase
    return m;
  endfunction

  // A seed that lands on zero after masking would lock the register: use 1.
  function automatic logic [15:0] safe_seed(input logic [15:0] seed, input int unsigned width);
    logic [15:0] mask;
    mask = (16'h1 << width) - 16'h1;
    return ((seed & mask) == 16'h0) ? 16'h1 : (seed & mask);
  endfunction

endpackage

// File: rtl/reauth_lfsr.sv
module reauth_lfsr
  import reauth_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter logic [15:0] SEED = 16'h0ACE
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] q_o
);
  localparam logic [15:0]  TAPS16 = fib_taps(W);
  localparam logic [15:0]  SEED16 = safe_seed(SEED, W);
  localparam logic [W-1:0] MASK   = TAPS16[W-1:0];
  localparam logic [W-1:0] INIT   = SEED16[W-1:0];

  function automatic logic [W-1:0] step(input logic [W-1:0] cur);
    return {cur[W-2:0], ^(cur & MASK)};
  endfunction

  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= INIT;
    else         q_q <= step(q_q);
  end

  assign q_o = q_q;
endmodule

// File: rtl/reauth_counter.sv
module reauth_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/reauth_ctrl.sv
module reauth_ctrl
  import reauth_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned IDX_LSB = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auth_i,
  input  logic [W-1:0]     rnd_i,
  input  logic [W-1:0]     cnt_i,
  output logic             clr_o,
  output logic             inc_o,
  output logic             arm_o,
  output logic             expire_o,
  output logic             running_o,
  output logic [W-1:0]     period_o,
  output logic             jump_o,
  output logic [IDX_W-1:0] idx_o
);
  function automatic logic [W-1:0] period_of(input logic [W-1:0] v);
    return (v == '0) ? W'(1) : v;
  endfunction

  function automatic logic [IDX_W-1:0] pick_idx(input logic [W-1:0] v);
    return v[IDX_LSB +: IDX_W];
  endfunction

  ctrl_state_e      state_q;
  logic [W-1:0]     period_q;
  logic [IDX_W-1:0] idx_q;
  logic             jump_q;
  logic             arm_w, expire_w;

  assign arm_w    = (state_q == ST_IDLE) && auth_i;
  assign expire_w = (state_q == ST_RUN) && (cnt_i == period_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      period_q <= '0;
      idx_q    <= '0;
      jump_q   <= 1'b0;
    end else begin
      jump_q <= expire_w;
      unique case (state_q)
        ST_IDLE: if (arm_w) begin
          period_q <= period_of(rnd_i);
          state_q  <= ST_RUN;
        end
        ST_RUN: if (expire_w) begin
          idx_q   <= pick_idx(rnd_i);
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign clr_o     = arm_w;
  assign inc_o     = (state_q == ST_RUN) && !expire_w;
  assign arm_o     = arm_w;
  assign expire_o  = expire_w;
  assign running_o = (state_q == ST_RUN);
  assign period_o  = period_q;
  assign jump_o    = jump_q;
  assign idx_o     = idx_q;
endmodule

// File: rtl/reauth_timer.sv
module reauth_timer #(
  parameter int unsigned LFSR_W  = 8,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned IDX_LSB = 0,
  parameter logic [15:0] SEED    = 16'h0ACE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auth_i,
  output logic             jump_o,
  output logic [IDX_W-1:0] jump_idx_o
);
  logic [LFSR_W-1:0] rnd_w;
  logic [LFSR_W-1:0] cnt_w;
  logic [LFSR_W-1:0] period_w;
  logic              clr_w, inc_w, arm_w, expire_w, running_w;

  reauth_lfsr #(.W(LFSR_W), .SEED(SEED)) u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .q_o   (rnd_w)
  );

  reauth_counter #(.W(LFSR_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_w),
    .inc_i (inc_w),
    .cnt_o (cnt_w)
  );

  reauth_ctrl #(.W(LFSR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .auth_i   (auth_i),
    .rnd_i    (rnd_w),
    .cnt_i    (cnt_w),
    .clr_o    (clr_w),
    .inc_o    (inc_w),
    .arm_o    (arm_w),
    .expire_o (expire_w),
    .running_o(running_w),
    .period_o (period_w),
    .jump_o   (jump_o),
    .idx_o    (jump_idx_o)
  );
endmodule

// File: rtl/reauth_timer_chk.sv
module reauth_timer_chk #(
  parameter int unsigned LFSR_W = 8,
  parameter int unsigned IDX_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              auth_i,
  input logic              jump_o,
  input logic [IDX_W-1:0]  jump_idx_o,
  input logic [LFSR_W-1:0] rnd_w,
  input logic [LFSR_W-1:0] cnt_w,
  input logic [LFSR_W-1:0] period_w,
  input logic              arm_w,
  input logic              expire_w,
  input logic              running_w
);
  p_lfsr_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_w != '0);

  p_pulse_source_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |-> $past(expire_w));

  p_arm_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_w |=> (running_w && cnt_w == '0 &&
               period_w == (($past(rnd_w) == '0) ? LFSR_W'(1) : $past(rnd_w))));

  p_count_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_w |-> (cnt_w <= period_w));

  p_expire_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_w |=> (jump_o && !running_w));

  p_pulse_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |=> !jump_o);

  p_idx_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !expire_w |=> $stable(jump_idx_o));

  p_auth_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_w && auth_i && !expire_w) |=> (running_w && cnt_w == $past(cnt_w) + LFSR_W'(1)));
endmodule

bind reauth_timer reauth_timer_chk #(.LFSR_W(LFSR_W), .IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .auth_i    (auth_i),
  .jump_o    (jump_o),
  .jump_idx_o(jump_idx_o),
  .rnd_w     (rnd_w),
  .cnt_w     (cnt_w),
  .period_w  (period_w),
  .arm_w     (arm_w),
  .expire_w  (expire_w),
  .running_w (running_w)
);

// File: tb/reauth_timer_tb.sv
module reauth_timer_tb;
  localparam int unsigned LW = 8;
  localparam int unsigned IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          auth = 1'b0;
  logic          jump;
  logic [IW-1:0] idx;
  logic [LW-1:0] ref_rnd;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  reauth_timer #(.LFSR_W(LW), .IDX_W(IW), .IDX_LSB(0), .SEED(16'h0ACE)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .auth_i    (auth),
    .jump_o    (jump),
    .jump_idx_o(idx)
  );

  // Bench model of R2: feedback from taps 8,6,5,4 taken one by one.
  function automatic logic [LW-1:0] ref_step(input logic [LW-1:0] v);
    logic fb;
    fb = v[7];
    fb = fb ^ v[5];
    fb = fb ^ v[4];
    fb = fb ^ v[3];
    return (v << 1) | LW'(fb);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) ref_rnd <= 8'hCE;
    else        ref_rnd <= ref_step(ref_rnd);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Starts at a negedge with the controller idle. keep=1 leaves auth high in
  // the pulse cycle and returns there; otherwise checks the cycle after it.
  task automatic do_window(input bit wiggle, input bit keep, input string tag);
    int p;
    int early;
    logic [IW-1:0] exp_idx;
    early = 0;
    exp_idx = '0;
    auth = 1'b1;
    p = (ref_rnd == 0) ? 1 : int'(ref_rnd);   // R4
    tick();
    for (int k = 1; k <= p + 1; k++) begin
      if (jump) early++;
      if (wiggle) auth = k[0];               // R8 activity during window
      else        auth = 1'b0;
      if (k == p + 1) begin
        exp_idx = ref_rnd[IW-1:0];           // R6
        auth = keep;
      end else begin
        tick();
      end
    end
    tick();
    check(early == 0, {"R5 no early pulse ", tag}, early, 0);
    check(jump == 1'b1, {"R5 pulse timing ", tag}, int'(jump), 1);
    check(idx == exp_idx, {"R6 index ", tag}, int'(idx), int'(exp_idx));
    if (!keep) begin
      tick();
      check(jump == 1'b0, {"R7 single pulse ", tag}, int'(jump), 0);
      check(idx == exp_idx, {"R7 index held ", tag}, int'(idx), int'(exp_idx));
    end
  endtask

  task automatic t_reset();
    check(jump == 1'b0, "R1 jump in reset", int'(jump), 0);
    check(idx == '0, "R1 index in reset", int'(idx), 0);
    rst_n = 1'b1;
    tick();
    check(jump == 1'b0 && idx == '0, "R1 first cycle", int'({jump, idx}), 0);
  endtask

  task automatic t_first_window();
    // R1/R2: the first period is the seed stepped once, checked through timing.
    do_window(1'b0, 1'b0, "after reset");
  endtask

  task automatic t_idle_quiet();
    int seen;
    logic [IW-1:0] held;
    seen = 0;
    held = idx;
    auth = 1'b0;
    for (int k = 0; k < 150; k++) begin
      if (jump) seen++;
      tick();
    end
    check(seen == 0, "R3 no request while idle", seen, 0);
    check(idx == held, "R7 index held while idle", int'(idx), int'(held));
  endtask

  task automatic t_gap_windows();
    // R2: the register keeps stepping while idle, so gaps change the period.
    for (int g = 1; g <= 3; g++) begin
      for (int k = 0; k < g * 7; k++) tick();
      do_window(1'b0, 1'b0, "after gap");
    end
  endtask

  task automatic t_auth_noise();
    do_window(1'b1, 1'b0, "R8 auth toggled");
  endtask

  task automatic t_back_to_back();
    // R9: auth held across the pulse, the next window starts at the edge
    // ending the pulse with the register value of the pulse cycle.
    do_window(1'b0, 1'b1, "R9 first");
    do_window(1'b0, 1'b1, "R9 chained");
    do_window(1'b0, 1'b0, "R9 last");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_first_window();
    t_idle_quiet();
    t_gap_windows();
    t_auth_noise();
    t_back_to_back();
    t_idle_quiet();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule